// File: doc/BRIEF.md
# Stack-Relative Effective Address Unit

This unit forms operand addresses for an 8-bit accumulator processor whose instruction set is extended for compiled code that keeps locals and parameters on the stack. It receives a mode code, an 8-bit instruction offset and the X and Y index registers. It holds the 8-bit stack register S itself. From these it produces a 16-bit effective address. Direct modes add the offset to S, X or Y and answer in the same cycle. The two indirect modes fetch a little-endian pointer from the stack through a one-cycle synchronous read port, then add X or Y to that pointer.

The same unit also runs two frame-management operations. The stack-adjust operation adds a signed offset to S, which reserves a frame when the offset is negative and frees one when it is positive. The load-effective-address operation returns the full address of a stack slot, split into a high byte for X and a low byte for A, so that the slot can be pushed as a pointer argument. All stack addresses lie in page one, and the low byte wraps inside that page.

Top module: `stack_ea_unit`

## Requirements
- R1: After reset, S reads 0xFF, and `busy`, `addr_valid`, `lea_valid` and `mem_rd_en` are all low.
- R2: Mode 1 (S direct) raises `addr_valid` in the request cycle, with `ea` = {0x01, (S+offset) mod 256}.
- R3: Mode 2 (X direct) and mode 3 (Y direct) raise `addr_valid` in the request cycle, with `ea` = the register plus the offset, both zero-extended to 16 bits. The carry reaches bit 8.
- R4: Mode 5 takes the pointer at stack slot S+offset and adds Y. Mode 6 does the same and adds X. The pointer's low byte is read from {0x01, S+offset} and its high byte from {0x01, S+offset+1}, each wrapping within page one. The index is captured at the request and added unsigned to the 16-bit pointer, and the result wraps modulo 65536.
- R5: For an indirect request, the low-byte read is issued in the request cycle and the high-byte read in the next cycle. `busy` is high for the two cycles after the request, and `addr_valid` is high only in the second of them. Memory data is taken one cycle after each read.
- R6: A request that arrives while `busy` is high is ignored. It changes neither S nor the address being formed.
- R7: Mode 7 (stack adjust) adds the offset, read as two's complement, to S. The new S is visible after the next clock edge and wraps in 8 bits. `addr_valid` stays low.
- R8: Mode 4 (load effective address) raises `lea_valid` in the request cycle, with `lea_hi` = 0x01 and `lea_lo` = (S+offset) mod 256. S does not change.
- R9: Mode 0 does nothing: it issues no read, raises no valid and leaves S unchanged.
- R10: Every memory read the unit issues falls in page one (address bits 15:8 = 0x01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe for one operation |
| mode | input | 3 | Operation code (0 none, 1 S, 2 X, 3 Y, 4 lea, 5 (S),Y, 6 (S),X, 7 adjust) |
| offset | input | 8 | Instruction offset or signed adjust value |
| x_in | input | 8 | X register |
| y_in | input | 8 | Y register |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Pointer fetch in progress |
| addr_valid | output | 1 | `ea` holds a result this cycle |
| ea | output | 16 | Effective address |
| lea_valid | output | 1 | `lea_hi` and `lea_lo` hold a result this cycle |
| lea_hi | output | 8 | High byte of the stack slot address (to X) |
| lea_lo | output | 8 | Low byte of the stack slot address (to A) |
| s_q | output | 8 | Current stack register |

## Verification
The bench aims at the wrap points of page one. It fetches a pointer at S=0xFF with offset 0, where a unit that lets the carry escape would read the high byte from 0x0200 and not 0x0100. It drives X=0xFF with offset 0xFF, where dropping the carry would give 0x00FE and not 0x01FE. It adjusts S downward through zero, where sign handling done wrong would leave S at a large positive step. Random pointers plus an index check that carry reaches the high byte; a unit that added the index only to the low byte would miss by 256. Requests made while a fetch is in progress are stack adjusts; if the unit accepted them, S would move and the bench's model would disagree.

// File: rtl/stack_ea_unit.sv
module stack_ea_unit #(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] S_RESET    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [2:0]  mode,
  input  logic [7:0]  offset,
  input  logic [7:0]  x_in,
  input  logic [7:0]  y_in,
  output logic        mem_rd_en,
  output logic [15:0] mem_rd_addr,
  input  logic [7:0]  mem_rd_data,
  output logic        busy,
  output logic        addr_valid,
  output logic [15:0] ea,
  output logic        lea_valid,
  output logic [7:0]  lea_hi,
  output logic [7:0]  lea_lo,
  output logic [7:0]  s_q
);
  localparam logic [2:0] M_NONE = 3'd0, M_SDIR = 3'd1, M_XDIR = 3'd2, M_YDIR = 3'd3,
                         M_LEA  = 3'd4, M_SIY  = 3'd5, M_SIX  = 3'd6, M_ADJ  = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_FIN} st_t;
  st_t st;

  logic [7:0] slot_q, idx_q, lo_q;
  wire        accept   = req && (st == ST_IDLE);
  wire [7:0]  slot     = s_q + offset;
  wire        indirect = (mode == M_SIY) || (mode == M_SIX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      s_q    <= S_RESET;
      slot_q <= '0;
      idx_q  <= '0;
      lo_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          if (indirect) begin
            st     <= ST_HI;
            slot_q <= slot;
            idx_q  <= (mode == M_SIY) ? y_in : x_in;
          end else if (mode == M_ADJ) begin
            s_q <= slot;
          end
        end
        ST_HI: begin
          lo_q <= mem_rd_data;
          st   <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st != ST_IDLE);
  assign lea_hi = STACK_PAGE;
  assign lea_lo = slot;

  always_comb begin
    mem_rd_en   = 1'b0;
    mem_rd_addr = '0;
    addr_valid  = 1'b0;
    ea          = '0;
    lea_valid   = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        case (mode)
          M_SDIR: begin addr_valid = 1'b1; ea = {STACK_PAGE, slot}; end
          M_XDIR: begin addr_valid = 1'b1; ea = {8'h00, x_in} + {8'h00, offset}; end
          M_YDIR: begin addr_valid = 1'b1; ea = {8'h00, y_in} + {8'h00, offset}; end
          M_LEA:  lea_valid = 1'b1;
          M_SIY, M_SIX: begin mem_rd_en = 1'b1; mem_rd_addr = {STACK_PAGE, slot}; end
          default: ;
        endcase
      end
      ST_HI: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = {STACK_PAGE, slot_q + 8'd1};
      end
      default: begin
        addr_valid = 1'b1;
        ea         = {mem_rd_data, lo_q} + {8'h00, idx_q};
      end
    endcase
  end

  p_adjust_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && mode == M_ADJ) |=> (s_q - $past(s_q)) == $past(offset));
  p_valid_after_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (busy && addr_valid));
  p_no_valid_first_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !addr_valid);
  p_s_held_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(s_q));
  p_page_one_reads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr[15:8] == STACK_PAGE));
  p_single_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && lea_valid));
endmodule

// File: tb/stack_ea_unit_tb_top.sv
`timescale 1ns/1ps
module stack_ea_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] offset = '0, x_in = '0, y_in = '0;
  logic mem_rd_en, busy, addr_valid, lea_valid;
  logic [15:0] mem_rd_addr, ea;
  logic [7:0] mem_rd_data, lea_hi, lea_lo, s_q;
  logic [15:0] raddr = '0;
  int checks = 0, failures = 0;
  logic [7:0] s_model;

  always #2 clk = ~clk;

  stack_ea_unit dut_i (.clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .offset(offset),
    .x_in(x_in), .y_in(y_in), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .busy(busy), .addr_valid(addr_valid), .ea(ea),
    .lea_valid(lea_valid), .lea_hi(lea_hi), .lea_lo(lea_lo), .s_q(s_q));

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) raddr <= mem_rd_addr;
  assign mem_rd_data = memf(raddr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] m, input logic [7:0] off, input logic [7:0] x,
                    input logic [7:0] y, input logic [7:0] poke);
    logic [7:0] sa, idx;
    logic [15:0] ptr;
    @(negedge clk);
    req = 1'b1; mode = m; offset = off; x_in = x; y_in = y;
    #1;
    sa = s_model + off;
    case (m)
      3'd1: begin chk("R2 valid", addr_valid, 1); chk("R2 ea", ea, {8'h01, sa}); end
      3'd2: begin chk("R3 valid", addr_valid, 1); chk("R3 ea x", ea, 16'(x) + 16'(off)); end
      3'd3: begin chk("R3 valid", addr_valid, 1); chk("R3 ea y", ea, 16'(y) + 16'(off)); end
      3'd4: begin chk("R8 lea", {lea_valid, lea_hi, lea_lo}, {1'b1, 8'h01, sa});
                  chk("R8 no ea", addr_valid, 0); end
      3'd7: chk("R7 no valid", {addr_valid, lea_valid, mem_rd_en}, 0);
      3'd0: chk("R9 idle", {addr_valid, lea_valid, mem_rd_en}, 0);
      default: begin
        chk("R5 lo read", {mem_rd_en, mem_rd_addr}, {1'b1, 8'h01, sa});
        chk("R5 not busy yet", {busy, addr_valid}, 0);
      end
    endcase
    if (m == 3'd5 || m == 3'd6) begin
      idx = (m == 3'd5) ? y : x;
      ptr = {memf({8'h01, sa + 8'd1}), memf({8'h01, sa})};
      @(negedge clk);
      mode = 3'd7; offset = poke; x_in = ~x; y_in = ~y;
      #1;
      chk("R5 hi read", {busy, addr_valid, mem_rd_en, mem_rd_addr},
          {1'b1, 1'b0, 1'b1, 8'h01, sa + 8'd1});
      @(negedge clk);
      #1;
      chk("R4 ea", {busy, addr_valid, ea}, {1'b1, 1'b1, ptr + 16'(idx)});
    end else if (m == 3'd7) begin
      s_model = sa;
    end
    @(negedge clk);
    req = 1'b0;
    #1;
    chk("R6 R7 R9 s", {busy, s_q}, {1'b0, s_model});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {s_q, busy, addr_valid, lea_valid, mem_rd_en}, {8'hFF, 4'b0});
    @(negedge clk); rst_n = 1'b1;
    s_model = 8'hFF;
    op(3'd5, 8'h00, 8'h10, 8'h33, 8'h05);   // R4 pointer wraps 01FF -> 0100
    op(3'd6, 8'h00, 8'hFF, 8'h00, 8'hF0);   // R6 poke ignored
    op(3'd2, 8'hFF, 8'hFF, 8'h00, 8'h00);   // R3 carry to 0x01FE
    op(3'd3, 8'h80, 8'h00, 8'h80, 8'h00);
    op(3'd1, 8'h01, 8'h00, 8'h00, 8'h00);   // R2 wrap to 0100
    op(3'd4, 8'h02, 8'h00, 8'h00, 8'h00);   // R8
    op(3'd7, 8'h01, 8'h00, 8'h00, 8'h00);   // R7 FF -> 00
    op(3'd7, 8'hFE, 8'h00, 8'h00, 8'h00);   // R7 00 -> FE
    op(3'd0, 8'h12, 8'h00, 8'h00, 8'h00);   // R9
    for (int i = 0; i < 400; i++)
      op(3'($urandom % 8), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule